// File: doc/BRIEF.md
# Double-Data-Rate Write Burst Strobe Sequencer

This block produces the data phase of a double-data-rate memory write on the controller side. A write request names a burst length of two, four or eight beats. The block then drives a strobe output enable, a strobe level, one data word per strobe edge and one mask bit per word. Everything runs on an internal clock at twice the memory clock rate, so each cycle of `clk` is one half period of the memory clock. A rising strobe edge is a cycle where `dqsLevel` is high, and a falling edge is the next cycle where it is low. Analog pad timing, delay lines and the command bus are handled elsewhere.

Once a request is accepted, the block waits half a memory clock and then drives the strobe low for one cycle as a preamble. It then places beats on alternating strobe levels, drives a one-cycle low postamble and releases the enable. Beat words are pulled from the upstream source with a take strobe.

A second request accepted at the last pair boundary of the running burst follows it with no gap and no preamble. A truncation pulse masks every beat of the running burst that has not yet been placed. The strobe keeps running for the full burst length.

Top module: `ddr_wr_strobe_seq`

## Requirements
- R1: While and after reset, `dqsOe`, `dqsLevel` and `dmOut` are low, `dqOut` is zero and `reqReady` is high.
- R2: If a request is accepted at clock edge t0, the registered outputs behave as follows. After t0, `dqsOe` is low. After t0+1, the preamble shows: `dqsOe` high and `dqsLevel` low. After t0+2, the first beat shows with `dqsLevel` high.
- R3: Beat i of a burst is shown after edge t0+2+i. `dqsLevel` is high for even i and low for odd i, and `dqsOe` is high throughout.
- R4: After the last beat of a burst with no follower, `dqsOe` stays high with `dqsLevel` low for one cycle (postamble). `dqsOe` is low in the following cycle.
- R5: The length code `reqLen` maps as follows: 0 gives 2 beats, 1 gives 4 beats, and 2 or 3 gives 8 beats.
- R6: `reqReady` is high in the cycle before the edge that shows beat len-2 of the running burst. For a 2-beat burst this is the preamble cycle. A request accepted there shows its first beat right after the last beat of the running burst. There is no preamble or postamble between the two bursts, and the strobe keeps alternating.
- R7: Apart from the idle state and the slot of R6, `reqReady` is low. A request offered then is not taken.
- R8: A `truncIn` pulse sampled during the preamble, or during a cycle whose next edge shows another beat of the same burst, masks every later beat of that burst. Each masked beat has `dmOut` high, `dqOut` zero and no take pulse, while the strobe runs for the full length.
- R9: `truncIn` while idle has no effect. A truncation never masks beats of the following concatenated burst.
- R10: `beatTake` is high in exactly those cycles whose next edge shows an unmasked beat. `beatData` is captured at that edge and shown on `dqOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the memory clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Write request offered |
| reqLen | input | 2 | Burst length code (see R5) |
| reqReady | output | 1 | Request can be taken this cycle |
| truncIn | input | 1 | Truncate the running burst; later beats are masked |
| beatData | input | DATA_W | Next data word from the upstream source |
| beatTake | output | 1 | `beatData` is consumed at the coming edge |
| dqsOe | output | 1 | Strobe output enable (low means high impedance) |
| dqsLevel | output | 1 | Strobe level |
| dqOut | output | DATA_W | Data word for the current strobe edge |
| dmOut | output | 1 | Mask for the current data word |

## Verification
The hardest case to reach is the concatenation slot. It is a single cycle per burst, and its position depends on the running burst's length. A request one cycle early or late either stalls or leaves a gap. The directed tasks count cycles from the acceptance edge and raise the second request in exactly that cycle for several length pairs. Truncation is driven inside the preamble cycle and again just before a concatenation, to show that masking starts at the right beat and stops at the burst boundary.

// File: rtl/wburst_pkg.sv
package wburst_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRE,
    PH_DATA,
    PH_POST
  } phase_t;

  localparam int IDX_W = 4;

  // next-cycle values handed from control to datapath
  typedef struct packed {
    logic oeNext;
    logic dqsNext;
    logic loadBeat;
    logic maskBeat;
  } dpCtl_t;

  function automatic logic [IDX_W-1:0] lastIdxOf(input logic [1:0] code);
    case (code)
      2'd0:    return IDX_W'(1);
      2'd1:    return IDX_W'(3);
      default: return IDX_W'(7);
    endcase
  endfunction

endpackage

// File: rtl/wburst_ctrl.sv
module wburst_ctrl
  import wburst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqLen,
  output logic       reqReady,
  input  logic       truncIn,
  output logic       beatTake,
  output dpCtl_t     dpCtl
);

  phase_t           phase, phaseN;
  logic [IDX_W-1:0] idx, idxN, lastIdx, lastIdxN, pendLast;
  logic             pendValid, pendValidN, cutFlag, cutFlagN;
  logic             accept, concatSlot, cutNow, beatLoad, beatMask;

  // the edge after this cycle shows beat len-2: last pair boundary
  assign concatSlot = (phase == PH_DATA && lastIdx >= IDX_W'(3) && idx == lastIdx - IDX_W'(2))
                    || (phase == PH_PRE && lastIdx == IDX_W'(1));
  assign reqReady   = !pendValid && (phase == PH_IDLE || concatSlot);
  assign accept     = reqValid && reqReady;
  assign cutNow     = truncIn && (phase == PH_PRE || (phase == PH_DATA && idx != lastIdx));

  always_comb begin
    phaseN     = phase;
    idxN       = idx;
    lastIdxN   = lastIdx;
    pendValidN = pendValid;
    cutFlagN   = cutFlag || cutNow;
    beatLoad   = 1'b0;
    beatMask   = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (pendValid) begin
          phaseN     = PH_PRE;
          lastIdxN   = pendLast;
          pendValidN = 1'b0;
          cutFlagN   = 1'b0;
        end
      end
      PH_PRE: begin
        phaseN   = PH_DATA;
        idxN     = '0;
        beatLoad = 1'b1;
        beatMask = cutFlagN;
      end
      PH_DATA: begin
        if (idx != lastIdx) begin
          idxN     = idx + IDX_W'(1);
          beatLoad = 1'b1;
          beatMask = cutFlagN;
        end else if (pendValid) begin
          idxN       = '0;
          lastIdxN   = pendLast;
          pendValidN = 1'b0;
          cutFlagN   = 1'b0;
          beatLoad   = 1'b1;
        end else begin
          phaseN = PH_POST;
        end
      end
      default: begin
        phaseN   = PH_IDLE;
        cutFlagN = 1'b0;
      end
    endcase
    // acceptance needs an empty slot, consumption a full one: never both
    if (accept) pendValidN = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      idx       <= '0;
      lastIdx   <= '0;
      pendLast  <= '0;
      pendValid <= 1'b0;
      cutFlag   <= 1'b0;
    end else begin
      phase     <= phaseN;
      idx       <= idxN;
      lastIdx   <= lastIdxN;
      pendValid <= pendValidN;
      cutFlag   <= cutFlagN;
      if (accept) pendLast <= lastIdxOf(reqLen);
    end
  end

  assign beatTake         = beatLoad && !beatMask;
  assign dpCtl.oeNext     = (phaseN != PH_IDLE);
  assign dpCtl.dqsNext    = (phaseN == PH_DATA) && !idxN[0];
  assign dpCtl.loadBeat   = beatLoad;
  assign dpCtl.maskBeat   = beatMask;

endmodule

// File: rtl/wburst_dpath.sv
module wburst_dpath
  import wburst_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [DATA_W-1:0] beatData,
  output logic              dqsOe,
  output logic              dqsLevel,
  output logic [DATA_W-1:0] dqOut,
  output logic              dmOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dqsOe    <= 1'b0;
      dqsLevel <= 1'b0;
      dqOut    <= '0;
      dmOut    <= 1'b0;
    end else begin
      dqsOe    <= dpCtl.oeNext;
      dqsLevel <= dpCtl.dqsNext;
      dmOut    <= dpCtl.loadBeat && dpCtl.maskBeat;
      dqOut    <= (dpCtl.loadBeat && !dpCtl.maskBeat) ? beatData : '0;
    end
  end

endmodule

// File: rtl/ddr_wr_strobe_seq.sv
module ddr_wr_strobe_seq
  import wburst_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqLen,
  output logic              reqReady,
  input  logic              truncIn,
  input  logic [DATA_W-1:0] beatData,
  output logic              beatTake,
  output logic              dqsOe,
  output logic              dqsLevel,
  output logic [DATA_W-1:0] dqOut,
  output logic              dmOut
);

  dpCtl_t dpCtl;

  wburst_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqLen   (reqLen),
    .reqReady (reqReady),
    .truncIn  (truncIn),
    .beatTake (beatTake),
    .dpCtl    (dpCtl)
  );

  wburst_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtl    (dpCtl),
    .beatData (beatData),
    .dqsOe    (dqsOe),
    .dqsLevel (dqsLevel),
    .dqOut    (dqOut),
    .dmOut    (dmOut)
  );

endmodule

// File: rtl/ddr_wr_strobe_seq_chk.sv
module ddr_wr_strobe_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              beatTake,
  input logic              dqsOe,
  input logic              dqsLevel,
  input logic [DATA_W-1:0] dqOut,
  input logic              dmOut
);

  // strobe only toggles while enabled
  p_level_needs_oe_r3: assert property (@(posedge clk) disable iff (!rstN)
    dqsLevel |-> dqsOe);

  // a high strobe level is always followed by a low one
  p_strobe_alternates_r3: assert property (@(posedge clk) disable iff (!rstN)
    dqsLevel |=> !dqsLevel);

  // enable rises into a low preamble
  p_preamble_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqsOe) |-> !dqsLevel);

  // enable drops only after a low postamble
  p_postamble_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dqsOe) |-> !$past(dqsLevel));

  // one pending request at most
  p_ready_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // masked beats carry no data and sit inside the strobe window
  p_mask_blanks_r8: assert property (@(posedge clk) disable iff (!rstN)
    dmOut |-> (dqOut == '0 && dqsOe));

  // a take is followed by an unmasked beat
  p_take_unmasked_r10: assert property (@(posedge clk) disable iff (!rstN)
    beatTake |=> (dqsOe && !dmOut));

endmodule

bind ddr_wr_strobe_seq ddr_wr_strobe_seq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .beatTake (beatTake),
  .dqsOe    (dqsOe),
  .dqsLevel (dqsLevel),
  .dqOut    (dqOut),
  .dmOut    (dmOut)
);

// File: tb/ddr_wr_strobe_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_wr_strobe_seq_tb_top;

  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [1:0]        reqLen = 2'd0;
  logic              reqReady;
  logic              truncIn = 1'b0;
  logic [DATA_W-1:0] beatData;
  logic              beatTake;
  logic              dqsOe, dqsLevel, dmOut;
  logic [DATA_W-1:0] dqOut;

  int  total = 0;
  int  failed = 0;
  bit  done = 1'b0;
  int  seqCount = 0;

  always #2 clk = ~clk;

  // upstream source: next word advances after each take edge
  assign beatData = 16'hB000 + seqCount[15:0];
  always @(posedge clk) if (beatTake) seqCount <= seqCount + 1;

  ddr_wr_strobe_seq #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .reqReady(reqReady), .truncIn(truncIn), .beatData(beatData),
    .beatTake(beatTake), .dqsOe(dqsOe), .dqsLevel(dqsLevel),
    .dqOut(dqOut), .dmOut(dmOut)
  );

  task automatic chk(input bit ok, input string msg);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int lenOf(input logic [1:0] code);
    return (code == 2'd0) ? 2 : (code == 2'd1) ? 4 : 8;
  endfunction

  // one or two bursts; cutAt = first masked beat of burst A (99: none);
  // pokeAt = cycle where a request is offered outside the slot (-1: none)
  task automatic runSeq(input logic [1:0] codeA, input bit withB, input logic [1:0] codeB,
                        input int cutAt, input int pokeAt, input string tag);
    int la, lb, tot, taken0, expTaken;
    la = lenOf(codeA);
    lb = withB ? lenOf(codeB) : 0;
    tot = la + lb;
    taken0 = seqCount;
    expTaken = 0;
    @(negedge clk);
    reqValid = 1'b1;
    reqLen = codeA;
    #1;
    chk(reqReady == 1'b1, $sformatf("%s R1 idle ready act=%b exp=1", tag, reqReady));
    @(posedge clk);
    for (int k = 0; k <= tot + 3; k++) begin
      logic eOe, eDqs, eDm;
      logic [DATA_W-1:0] eDq;
      string rq;
      @(negedge clk);
      reqValid = 1'b0;
      truncIn = 1'b0;
      eOe = 1'b1; eDqs = 1'b0; eDm = 1'b0; eDq = '0;
      if (k == 0) begin
        eOe = 1'b0; rq = "R2";
      end else if (k == 1) begin
        rq = "R2";
      end else if (k <= tot + 1) begin
        int idx, j;
        bit inB, masked;
        idx = k - 2;
        inB = idx >= la;
        j = inB ? idx - la : idx;
        masked = !inB && idx >= cutAt;
        eDqs = ((j % 2) == 0);
        eDm = masked;
        if (!masked) begin
          eDq = 16'hB000 + 16'(taken0 + expTaken);
          expTaken++;
        end
        rq = inB ? "R6" : (masked ? "R8" : "R3");
      end else if (k == tot + 2) begin
        rq = "R4";
      end else begin
        eOe = 1'b0; rq = "R4";
      end
      chk({dqsOe, dqsLevel, dmOut} == {eOe, eDqs, eDm} && dqOut == eDq,
          $sformatf("%s %s k=%0d oe/dqs/dm/dq act=%b%b%b/%h exp=%b%b%b/%h",
                    tag, rq, k, dqsOe, dqsLevel, dmOut, dqOut, eOe, eDqs, eDm, eDq));
      if (withB && la > 2 && k == la - 2)
        chk(reqReady == 1'b0, $sformatf("%s R7 early ready k=%0d act=%b exp=0", tag, k, reqReady));
      if (withB && k == la - 1) begin
        reqValid = 1'b1;
        reqLen = codeB;
        #1;
        chk(reqReady == 1'b1, $sformatf("%s R6 slot ready k=%0d act=%b exp=1", tag, k, reqReady));
      end
      if (k == pokeAt) begin
        reqValid = 1'b1;
        #1;
        chk(reqReady == 1'b0, $sformatf("%s R7 busy ready k=%0d act=%b exp=0", tag, k, reqReady));
      end
      if (k == cutAt + 1) truncIn = 1'b1;
    end
    chk(seqCount - taken0 == expTaken,
        $sformatf("%s R10 takes act=%0d exp=%0d", tag, seqCount - taken0, expTaken));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk({dqsOe, dqsLevel, dmOut} == 3'b000 && dqOut == '0,
        $sformatf("R1 reset outputs act=%b%b%b/%h exp=000/0000", dqsOe, dqsLevel, dmOut, dqOut));
    chk(reqReady == 1'b1, $sformatf("R1 reset ready act=%b exp=1", reqReady));
  endtask

  task automatic t_lengths();
    runSeq(2'd0, 1'b0, 2'd0, 99, -1, "R5 len2");
    runSeq(2'd1, 1'b0, 2'd0, 99, -1, "R5 len4");
    runSeq(2'd2, 1'b0, 2'd0, 99, -1, "R5 len8");
    runSeq(2'd3, 1'b0, 2'd0, 99, -1, "R5 code3");
  endtask

  task automatic t_concat();
    runSeq(2'd1, 1'b1, 2'd1, 99, -1, "R6 4+4");
    runSeq(2'd0, 1'b1, 2'd2, 99, -1, "R6 2+8");
    runSeq(2'd2, 1'b1, 2'd0, 99, -1, "R6 8+2");
  endtask

  task automatic t_busy();
    runSeq(2'd2, 1'b0, 2'd0, 99, 3, "R7 poke");
  endtask

  task automatic t_trunc();
    runSeq(2'd2, 1'b0, 2'd0, 3, -1, "R8 cut3");
    runSeq(2'd1, 1'b0, 2'd0, 0, -1, "R8 cutPre");
    runSeq(2'd1, 1'b1, 2'd1, 2, -1, "R9 cutThenConcat");
  endtask

  task automatic t_idleTrunc();
    @(negedge clk);
    truncIn = 1'b1;
    @(negedge clk);
    truncIn = 1'b0;
    chk(dqsOe == 1'b0 && dmOut == 1'b0,
        $sformatf("R9 idle trunc oe/dm act=%b%b exp=00", dqsOe, dmOut));
    runSeq(2'd1, 1'b0, 2'd0, 99, -1, "R9 afterIdleTrunc");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_reset();
    t_lengths();
    t_concat();
    t_busy();
    t_trunc();
    t_idleTrunc();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule